// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block keeps the machine-level control and status registers of a small 32-bit hart and runs the trap entry and trap return sequences. A pipeline drives it with a CSR access port (address, operation, write data), a synchronous exception request carrying a cause code and a trap value, a return request, and three interrupt request lines. It answers with the current privilege level, combinational CSR read data, and a one-cycle redirect strobe with the new fetch address.

On a trap the unit saves the resume address, records the cause and the trap value, stacks the interrupt enable and the privilege, and moves the hart into Machine mode. The handler address comes from the trap-vector register, either one common entry point or a table indexed by interrupt cause. On a return it jumps back to the saved address and unstacks enable and privilege. All control pins are plain level signals. The unit accepts an access or event in every cycle and applies no back-pressure, so no ready signal exists.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the privilege is Machine (2'b11), redirect_valid is 0, and mstatus, mie, mtvec, mepc, mcause, mtval and mscratch read 0.
- R2: The privilege is 2 bits (00 User, 01 Supervisor, 11 Machine) and never becomes 10. A CSR write that puts 10 into mstatus bits 12:11 leaves that field unchanged.
- R3: csr_op encodes 00 none, 01 write, 10 set bits, 11 clear bits. csr_rdata shows the addressed register in the same cycle. A write takes effect at the next clock edge. Addresses: 0x300 mstatus, 0x304 mie, 0x305 mtvec, 0x340 mscratch, 0x341 mepc, 0x342 mcause, 0x343 mtval, 0x344 mip, 0xF14 mhartid.
- R4: Only these bits are writable: mstatus bit 3 (global enable), bit 7 (previous enable) and bits 12:11 (previous privilege); mie bits 3, 7 and 11; mtvec every bit except bit 1, which reads 0; mepc every bit except bits 1:0, which read 0.
- R5: mhartid reads the HART_ID parameter, and writes to it are ignored. mip is read-only and shows irq_sw, irq_timer and irq_ext at bits 3, 7 and 11. Unmapped addresses read 0 and ignore writes.
- R6: An exception sets redirect_valid for exactly one cycle after the request edge. At that edge mepc takes trap_pc with bits 1:0 cleared, mcause takes the cause with bit 31 = 0, and mtval takes exc_tval.
- R7: On any trap entry, the previous enable takes the global enable, the global enable clears, the previous privilege takes the current privilege, and the privilege becomes Machine.
- R8: An interrupt is taken when its line is high, its mie bit is set, and either the global enable is 1 or the privilege is below Machine.
- R9: Among eligible interrupts, external (code 11) wins over software (code 3), and software wins over timer (code 7). mcause then holds bit 31 = 1 with that code, and mtval is cleared.
- R10: The handler base is mtvec with bits 1:0 cleared. With mtvec bit 0 = 1, an interrupt goes to base + 4 x code. Exceptions, and every trap with bit 0 = 0, go to base.
- R11: A return redirects to mepc. The privilege takes the previous privilege, the global enable takes the previous enable, the previous enable becomes 1, and the previous privilege becomes User.
- R12: Within one cycle, an exception wins over an interrupt, an interrupt wins over a return, and all three win over a CSR write. A CSR write in a cycle that has a trap or return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_op | input | 2 | CSR operation code |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data or bit mask |
| csr_rdata | output | XLEN | Current value of the addressed CSR |
| exc_valid | input | 1 | Synchronous exception request |
| exc_cause | input | CAUSE_W | Exception code |
| exc_tval | input | XLEN | Trap value for the exception |
| trap_pc | input | XLEN | Address saved in mepc on a trap |
| mret_valid | input | 1 | Trap return request |
| irq_sw | input | 1 | Software interrupt line |
| irq_timer | input | 1 | Timer interrupt line |
| irq_ext | input | 1 | External interrupt line |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | XLEN | Redirect target |
| priv | output | 2 | Current privilege level |

## Verification
CSR read data is combinational. It is due in the same cycle that the address is presented. CSR updates, trap state, privilege changes and the redirect strobe all appear after the one clock edge that sees the request, and the strobe drops again after the next edge. The bench changes inputs on the falling edge and reads results on the following falling edge. That is one register stage after the request, and the mid-cycle timing keeps every read clear of the updating edge. Read data is checked a short delay after the address is set, within the same low phase.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_MTVAL    = 12'h343;
  localparam logic [11:0] A_MIP      = 12'h344;
  localparam logic [11:0] A_MHARTID  = 12'hF14;

  localparam int ST_GIE   = 3;
  localparam int ST_PGIE  = 7;
  localparam int ST_PPRIV = 11;

  // source index: 0 software, 1 timer, 2 external
  localparam int NUM_IRQ = 3;
  localparam int IRQ_CODE [NUM_IRQ] = '{3, 7, 11};
  // source index by rank, rank 0 wins
  localparam int IRQ_RANK [NUM_IRQ] = '{2, 0, 1};

endpackage

// File: rtl/mtrap_irq_arb.sv
module mtrap_irq_arb
  import mtrap_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic [NUM_IRQ-1:0] pending,
  input  logic [NUM_IRQ-1:0] enable,
  input  logic               global_en,
  output logic               take,
  output logic [CAUSE_W-1:0] code
);

  logic [NUM_IRQ-1:0] eligible;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_elig
      assign eligible[g] = pending[g] & enable[g] & global_en;
    end
  endgenerate

  // walk from lowest rank to highest so the winner is assigned last
  always_comb begin
    take = 1'b0;
    code = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (eligible[IRQ_RANK[k]]) begin
        take = 1'b1;
        code = CAUSE_W'(IRQ_CODE[IRQ_RANK[k]]);
      end
    end
  end

endmodule

// File: rtl/mtrap_target.sv
module mtrap_target #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic [XLEN-1:0]    vec_base,
  input  logic               vec_mode,
  input  logic [XLEN-1:0]    ret_pc,
  input  logic               use_ret,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] code,
  output logic [XLEN-1:0]    target
);

  localparam int PAD_W = XLEN - CAUSE_W;

  logic [XLEN-1:0] slot_off;

  assign slot_off = {{PAD_W{1'b0}}, code} << 2;

  always_comb begin
    if (use_ret)                target = ret_pc;
    else if (is_irq && vec_mode) target = vec_base + slot_off;
    else                        target = vec_base;
  end

endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file
  import mtrap_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          CAUSE_W = 6,
  parameter int unsigned HART_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         csr_op,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]    exc_tval,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               irq_take,
  input  logic [CAUSE_W-1:0] irq_code,
  input  logic               mret_valid,
  input  logic [NUM_IRQ-1:0] irq_lines,
  output logic               ev_exc,
  output logic               ev_irq,
  output logic               ev_mret,
  output logic [1:0]         priv,
  output logic               gie,
  output logic [NUM_IRQ-1:0] irq_en,
  output logic [XLEN-1:0]    vec_base,
  output logic               vec_mode,
  output logic [XLEN-1:0]    ret_pc
);

  localparam logic [XLEN-1:0] ALIGN4   = ~XLEN'(3);
  localparam logic [XLEN-1:0] TVEC_MSK = ~XLEN'(2);

  logic [1:0]         priv_q;
  logic               gie_q;
  logic               pgie_q;
  logic [1:0]         ppriv_q;
  logic [NUM_IRQ-1:0] ien_q;
  logic [XLEN-1:0]    tvec_q;
  logic [XLEN-1:0]    epc_q;
  logic [XLEN-1:0]    cause_q;
  logic [XLEN-1:0]    tval_q;
  logic [XLEN-1:0]    scratch_q;

  logic               ev_csr;
  logic [XLEN-1:0]    wr_val;
  logic [XLEN-1:0]    cause_word;
  logic [XLEN-1:0]    status_word;
  logic [XLEN-1:0]    ien_word;
  logic [XLEN-1:0]    ip_word;

  function automatic logic [XLEN-1:0] csr_apply(input logic [1:0] op,
                                                input logic [XLEN-1:0] old_v,
                                                input logic [XLEN-1:0] wd);
    case (csr_op_e'(op))
      OP_WRITE: return wd;
      OP_SET:   return old_v | wd;
      OP_CLEAR: return old_v & ~wd;
      default:  return old_v;
    endcase
  endfunction

  // event precedence: exception, interrupt, return, CSR access
  assign ev_exc  = exc_valid;
  assign ev_irq  = irq_take & ~exc_valid;
  assign ev_mret = mret_valid & ~exc_valid & ~irq_take;
  assign ev_csr  = (csr_op != OP_NONE) & ~exc_valid & ~irq_take & ~mret_valid;

  always_comb begin
    status_word = '0;
    status_word[ST_GIE]              = gie_q;
    status_word[ST_PGIE]             = pgie_q;
    status_word[ST_PPRIV+1:ST_PPRIV] = ppriv_q;
    ien_word = '0;
    ip_word  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      ien_word[IRQ_CODE[i]] = ien_q[i];
      ip_word[IRQ_CODE[i]]  = irq_lines[i];
    end
  end

  always_comb begin
    case (csr_addr)
      A_MSTATUS:  csr_rdata = status_word;
      A_MIE:      csr_rdata = ien_word;
      A_MTVEC:    csr_rdata = tvec_q;
      A_MSCRATCH: csr_rdata = scratch_q;
      A_MEPC:     csr_rdata = epc_q;
      A_MCAUSE:   csr_rdata = cause_q;
      A_MTVAL:    csr_rdata = tval_q;
      A_MIP:      csr_rdata = ip_word;
      A_MHARTID:  csr_rdata = XLEN'(HART_ID);
      default:    csr_rdata = '0;
    endcase
  end

  assign wr_val = csr_apply(csr_op, csr_rdata, csr_wdata);

  always_comb begin
    cause_word = '0;
    cause_word[CAUSE_W-1:0] = ev_irq ? irq_code : exc_cause;
    cause_word[XLEN-1]      = ev_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q    <= PRIV_M;
      gie_q     <= 1'b0;
      pgie_q    <= 1'b0;
      ppriv_q   <= PRIV_U;
      ien_q     <= '0;
      tvec_q    <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
      scratch_q <= '0;
    end else if (ev_exc || ev_irq) begin
      epc_q   <= trap_pc & ALIGN4;
      cause_q <= cause_word;
      tval_q  <= ev_exc ? exc_tval : '0;
      pgie_q  <= gie_q;
      gie_q   <= 1'b0;
      ppriv_q <= priv_q;
      priv_q  <= PRIV_M;
    end else if (ev_mret) begin
      priv_q  <= ppriv_q;
      gie_q   <= pgie_q;
      pgie_q  <= 1'b1;
      ppriv_q <= PRIV_U;
    end else if (ev_csr) begin
      case (csr_addr)
        A_MSTATUS: begin
          gie_q  <= wr_val[ST_GIE];
          pgie_q <= wr_val[ST_PGIE];
          if (wr_val[ST_PPRIV+1:ST_PPRIV] != PRIV_RSVD)
            ppriv_q <= wr_val[ST_PPRIV+1:ST_PPRIV];
        end
        A_MIE: begin
          for (int i = 0; i < NUM_IRQ; i++) ien_q[i] <= wr_val[IRQ_CODE[i]];
        end
        A_MTVEC:    tvec_q    <= wr_val & TVEC_MSK;
        A_MSCRATCH: scratch_q <= wr_val;
        A_MEPC:     epc_q     <= wr_val & ALIGN4;
        A_MCAUSE:   cause_q   <= wr_val;
        A_MTVAL:    tval_q    <= wr_val;
        default: ;
      endcase
    end
  end

  assign priv     = priv_q;
  assign gie      = gie_q;
  assign irq_en   = ien_q;
  assign vec_base = tvec_q & ALIGN4;
  assign vec_mode = tvec_q[0];
  assign ret_pc   = epc_q;

  // R2: reserved privilege is never held
  a_r2_priv_legal: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != PRIV_RSVD);
  // R2: saved privilege is never reserved
  a_r2_ppriv_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ppriv_q != PRIV_RSVD);
  // R7: trap entry lands in Machine mode with the enable cleared
  a_r7_trap_to_m: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_exc || ev_irq) |=> (priv_q == PRIV_M && !gie_q));
  // R7: previous enable records the enable held before the trap
  a_r7_pgie_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_exc || ev_irq) |=> (pgie_q == $past(gie_q)));
  // R11: return restores the saved privilege and resets the saved one to User
  a_r11_mret_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mret |=> (priv_q == $past(ppriv_q) && ppriv_q == PRIV_U && pgie_q));
  // R12: an exception wins over a simultaneous interrupt
  a_r12_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && irq_take) |=> !cause_q[XLEN-1]);

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          CAUSE_W = 6,
  parameter int unsigned HART_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         csr_op,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]    exc_tval,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               mret_valid,
  input  logic               irq_sw,
  input  logic               irq_timer,
  input  logic               irq_ext,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [1:0]         priv
);

  logic [NUM_IRQ-1:0] irq_lines;
  logic [NUM_IRQ-1:0] irq_en;
  logic               gie;
  logic               global_en;
  logic               irq_take;
  logic [CAUSE_W-1:0] irq_code;
  logic               ev_exc;
  logic               ev_irq;
  logic               ev_mret;
  logic [XLEN-1:0]    vec_base;
  logic               vec_mode;
  logic [XLEN-1:0]    ret_pc;
  logic [XLEN-1:0]    target;

  assign irq_lines = {irq_ext, irq_timer, irq_sw};
  assign global_en = gie | (priv != PRIV_M);

  mtrap_irq_arb #(.CAUSE_W(CAUSE_W)) i_arb (
    .pending   (irq_lines),
    .enable    (irq_en),
    .global_en (global_en),
    .take      (irq_take),
    .code      (irq_code)
  );

  mtrap_csr_file #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HART_ID(HART_ID)) i_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_op     (csr_op),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .exc_valid  (exc_valid),
    .exc_cause  (exc_cause),
    .exc_tval   (exc_tval),
    .trap_pc    (trap_pc),
    .irq_take   (irq_take),
    .irq_code   (irq_code),
    .mret_valid (mret_valid),
    .irq_lines  (irq_lines),
    .ev_exc     (ev_exc),
    .ev_irq     (ev_irq),
    .ev_mret    (ev_mret),
    .priv       (priv),
    .gie        (gie),
    .irq_en     (irq_en),
    .vec_base   (vec_base),
    .vec_mode   (vec_mode),
    .ret_pc     (ret_pc)
  );

  mtrap_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_tgt (
    .vec_base (vec_base),
    .vec_mode (vec_mode),
    .ret_pc   (ret_pc),
    .use_ret  (ev_mret),
    .is_irq   (ev_irq),
    .code     (irq_code),
    .target   (target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= ev_exc | ev_irq | ev_mret;
      if (ev_exc || ev_irq || ev_mret) redirect_pc <= target;
    end
  end

  // R6: an exception request always produces a redirect on the next cycle
  a_r6_exc_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> redirect_valid);
  // R8: no interrupt is granted in Machine mode with the global enable off
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (gie || priv != PRIV_M));
  // R10: every redirect target is word aligned
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc[1:0] == 2'b00));

endmodule

// File: tb/test_mtrap_unit.sv
module test_mtrap_unit;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int CW = 6;
  localparam int NVEC = 14;

  localparam logic [11:0] AS = 12'h300, AIE = 12'h304, ATV = 12'h305,
                          ASC = 12'h340, AEP = 12'h341, ACA = 12'h342,
                          ATL = 12'h343, AIP = 12'h344, AHI = 12'hF14;

  // {op, addr, wdata, expected readback}
  localparam logic [77:0] VEC [NVEC] = '{
    {2'b01, ASC,     32'hDEADBEEF, 32'hDEADBEEF},
    {2'b10, ASC,     32'h00000010, 32'hDEADBEFF},
    {2'b11, ASC,     32'h0000000F, 32'hDEADBEF0},
    {2'b01, AIE,     32'hFFFFFFFF, 32'h00000888},
    {2'b11, AIE,     32'h00000008, 32'h00000880},
    {2'b01, ATV,     32'h00001003, 32'h00001001},
    {2'b01, AEP,     32'h00002007, 32'h00002004},
    {2'b01, AS,      32'hFFFFFFFF, 32'h00001888},
    {2'b01, AS,      32'h00001000, 32'h00001800},
    {2'b01, AHI,     32'h00000000, 32'h00000005},
    {2'b01, AIP,     32'hFFFFFFFF, 32'h00000000},
    {2'b01, ACA,     32'h8000000B, 32'h8000000B},
    {2'b01, ATL,     32'h12345678, 32'h12345678},
    {2'b01, 12'h7C0, 32'hFFFFFFFF, 32'h00000000}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      csr_op = 2'b00;
  logic [11:0]     csr_addr = 12'h0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic            exc_valid = 1'b0;
  logic [CW-1:0]   exc_cause = '0;
  logic [XLEN-1:0] exc_tval = '0;
  logic [XLEN-1:0] trap_pc = '0;
  logic            mret_valid = 1'b0;
  logic            irq_sw = 1'b0, irq_timer = 1'b0, irq_ext = 1'b0;
  logic            redirect_valid;
  logic [XLEN-1:0] redirect_pc;
  logic [1:0]      priv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtrap_unit #(.XLEN(XLEN), .CAUSE_W(CW), .HART_ID(5)) i_mtrap_unit (
    .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_tval(exc_tval), .trap_pc(trap_pc),
    .mret_valid(mret_valid), .irq_sw(irq_sw), .irq_timer(irq_timer),
    .irq_ext(irq_ext), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .priv(priv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    csr_addr = a;
    #1;
    chk(req, csr_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d);
    csr_op = op; csr_addr = a; csr_wdata = d;
    step();
    csr_op = 2'b00;
  endtask

  task automatic do_mret();
    mret_valid = 1'b1;
    step();
    mret_valid = 1'b0;
  endtask

  task automatic pulse_irq(input logic s, input logic t, input logic e, input logic [31:0] pc);
    trap_pc = pc; irq_sw = s; irq_timer = t; irq_ext = e;
    step();
    irq_sw = 0; irq_timer = 0; irq_ext = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 priv", 32'(priv), 32'h3);
    chk("R1 redirect_valid", 32'(redirect_valid), 32'h0);
    rd("R1 mstatus", AS, 32'h0);
    rd("R1 mtvec", ATV, 32'h0);
    rd("R1 mcause", ACA, 32'h0);

    // R3 R4 R5 R2: table of accesses
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][77:76], VEC[i][75:64], VEC[i][63:32]);
      rd($sformatf("R3/R4/R5/R2 vec %0d", i), VEC[i][75:64], VEC[i][31:0]);
    end

    // R5 R8: mip reflects the line; disabled globally in Machine mode
    irq_timer = 1'b1;
    rd("R5 mip timer", AIP, 32'h80);
    step();
    irq_timer = 1'b0;
    chk("R8 gated by global enable", 32'(redirect_valid), 32'h0);

    // R6 R7 R10: exception in vectored mode goes to base
    exc_valid = 1; exc_cause = 6'd2; exc_tval = 32'hBAD; trap_pc = 32'h403;
    step();
    exc_valid = 0;
    chk("R6 redirect_valid", 32'(redirect_valid), 32'h1);
    chk("R10 exc to base", redirect_pc, 32'h1000);
    chk("R7 priv", 32'(priv), 32'h3);
    rd("R6 mepc", AEP, 32'h400);
    rd("R6 mcause", ACA, 32'h2);
    rd("R6 mtval", ATL, 32'hBAD);
    rd("R7 mstatus", AS, 32'h1800);
    step();
    chk("R6 strobe one cycle", 32'(redirect_valid), 32'h0);

    // R11: return to User with enable restored
    wr(2'b01, AS, 32'h80);
    do_mret();
    chk("R11 redirect", redirect_pc, 32'h400);
    chk("R11 priv", 32'(priv), 32'h0);
    rd("R11 mstatus", AS, 32'h88);

    // R8 R9 R10: timer from User, software pending but disabled
    pulse_irq(1, 1, 0, 32'h500);
    chk("R10 vectored timer", redirect_pc, 32'h101C);
    rd("R9 mcause timer", ACA, 32'h80000007);
    rd("R9 mtval cleared", ATL, 32'h0);
    rd("R6 mepc irq", AEP, 32'h500);
    rd("R7 mstatus irq", AS, 32'h80);
    chk("R7 priv irq", 32'(priv), 32'h3);

    // R9: external beats software and timer
    wr(2'b01, AIE, 32'h888);
    wr(2'b01, AS, 32'h1808);
    pulse_irq(1, 1, 1, 32'h600);
    chk("R9 ext target", redirect_pc, 32'h102C);
    rd("R9 ext cause", ACA, 32'h8000000B);

    // R9: software beats timer
    wr(2'b01, AIE, 32'h088);
    wr(2'b01, AS, 32'h1808);
    pulse_irq(1, 1, 0, 32'h700);
    chk("R9 sw target", redirect_pc, 32'h100C);
    rd("R9 sw cause", ACA, 32'h80000003);

    // R8: below Machine mode the global enable is ignored
    wr(2'b01, AS, 32'h0);
    do_mret();
    chk("R11 priv user", 32'(priv), 32'h0);
    rd("R11 mstatus off", AS, 32'h80);
    wr(2'b01, AS, 32'h0);
    rd("R8 enable off in user", AS, 32'h0);
    pulse_irq(0, 1, 0, 32'h800);
    chk("R8 taken below M", 32'(redirect_valid), 32'h1);
    rd("R8 cause", ACA, 32'h80000007);

    // R10: direct mode sends interrupts to base
    wr(2'b01, ATV, 32'h2000);
    wr(2'b01, AIE, 32'h800);
    wr(2'b01, AS, 32'h1808);
    pulse_irq(0, 0, 1, 32'h900);
    chk("R10 direct", redirect_pc, 32'h2000);

    // R12: exception beats interrupt, return and CSR write
    wr(2'b01, AS, 32'h1808);
    exc_valid = 1; exc_cause = 6'd11; exc_tval = 32'h0; trap_pc = 32'hA00;
    irq_ext = 1; mret_valid = 1;
    csr_op = 2'b01; csr_addr = ASC; csr_wdata = 32'h11111111;
    step();
    exc_valid = 0; irq_ext = 0; mret_valid = 0; csr_op = 2'b00;
    rd("R12 cause exception", ACA, 32'hB);
    rd("R12 csr write dropped", ASC, 32'hDEADBEF0);
    chk("R12 target", redirect_pc, 32'h2000);

    // R12: interrupt beats return
    wr(2'b01, AS, 32'h1808);
    irq_ext = 1; mret_valid = 1; trap_pc = 32'hB00;
    step();
    irq_ext = 0; mret_valid = 0;
    rd("R12 irq over mret", ACA, 32'h8000000B);
    chk("R12 priv stays M", 32'(priv), 32'h3);

    // R11 R2: return into Supervisor
    wr(2'b01, AS, 32'h0800);
    do_mret();
    chk("R11 priv supervisor", 32'(priv), 32'h1);
    chk("R2 priv not reserved", 32'(priv == 2'b10), 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule